// File: doc/BRIEF.md
# Tone Cadence Timer

This block switches a digital tone oscillator on and off in a programmable rhythm. It works from a sample tick at 8 kHz, so one tick is 125 µs. A single counter times both parts of the rhythm: an "on" stretch (the active interval) and an "off" stretch (the inactive interval). Each interval has its own enable bit. The two enables together choose the pattern:

- **Continuous:** the tone simply follows the software enable.
- **Single-shot:** one on-burst, after which the tone stays off.
- **Repeating:** the on-burst and the off-gap alternate.

The block raises a one-cycle event each time either interval runs out.

An optional zero-crossing mode is set by a build parameter, for the one generator that supports it. In this mode the gated enable changes only on a sample whose sign differs from the sign of the previous sample. As a result, bursts start and stop where the waveform crosses zero. The block never sees the oscillator arithmetic. It receives the sign of each sample and the sample-valid tick, and it returns the gated enable.

Top module: `tone_cadence_timer`

## Requirements
- R1: After reset, `tone_on`, `act_irq` and `inact_irq` are all 0.
- R2: With `act_en`=0, the tone runs continuously while `osc_en`=1. Both durations and `inact_en` have no effect.
- R3: With `act_en`=1 and `inact_en`=1, the enable on the second clock edge after sample tick n equals ((n mod (A+I)) < A). Here A=`act_len`, I=`inact_len`, and ticks are counted from 1 after `osc_en` rises. The 16-bit durations are in ticks of 125 µs.
- R4: `act_irq` is a one-cycle pulse on the cycle right after the tick that ends an active interval. `inact_irq` is the same for an inactive interval. The two never pulse together, and neither pulses except after a tick.
- R5: With `act_en`=1 and `inact_en`=0, the tone plays for the first A ticks and then stays off. `act_irq` pulses once, after tick A.
- R6: A duration of 0 skips its interval, and no event is raised for it. If A=0 the tone never sounds. If I=0 the tone sounds without a gap, and `act_irq` repeats every A ticks. If both are 0, the tone is off and no event is raised.
- R7: Clearing `osc_en` stops the counter and raises no further events. With zero-crossing mode off, `tone_on` is 0 two edges later. Setting `osc_en` again restarts the pattern with the active interval, from a count of 0.
- R8: With `zc_mode`=1, `tone_on` changes only on a tick whose `smp_sign` differs from the sign of the previous tick. It then takes the ungated enable as it stood before that tick. A tone that is switched off keeps sounding until such a tick arrives.
- R9: When the build parameter `ZC_CAPABLE` is 0, `zc_mode` is ignored and the output behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample tick (8 kHz), one clock wide |
| smp_sign | input | 1 | Sign of the current oscillator sample (1 = negative) |
| osc_en | input | 1 | Software enable of the tone |
| act_en | input | 1 | Enables timing of the active interval |
| inact_en | input | 1 | Enables timing of the inactive interval |
| zc_mode | input | 1 | Gate start and stop to sign changes |
| act_len | input | CNT_W | Active duration in ticks |
| inact_len | input | CNT_W | Inactive duration in ticks |
| tone_on | output | 1 | Gated oscillator enable |
| act_irq | output | 1 | Active interval expired pulse |
| inact_irq | output | 1 | Inactive interval expired pulse |

## Verification
Two events can fall on the same sample tick: the expiry of an interval, which changes the ungated enable, and a sign change, which opens the zero-crossing gate. The bench provokes this by toggling the sign with a period equal to the active duration, so the two events coincide. It then expects the gate to latch the enable value from before the expiry, and the new value to wait for the next sign change. The expected output is computed from the tick index and the latest crossing tick. The same stimulus is also applied to a second instance built without zero-crossing support, which must follow the plain cadence.

// File: rtl/tone_cadence_timer.sv
module tone_cadence_timer #(
  parameter int CNT_W      = 16,
  parameter bit ZC_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_sign,
  input  logic             osc_en,
  input  logic             act_en,
  input  logic             inact_en,
  input  logic             zc_mode,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] inact_len,
  output logic             tone_on,
  output logic             act_irq,
  output logic             inact_irq
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             started;
  logic             done;
  logic             phase;
  logic             prev_sign;
  logic [CNT_W-1:0] cnt;

  wire [CNT_W-1:0] cur_len  = phase ? inact_len : act_len;
  wire             cur_zero = (cur_len == ZERO);
  wire             running  = started & ~done & act_en;
  wire             step     = running & smp_valid & ~cur_zero;
  wire             expire   = step & (cnt == cur_len - ONE);
  wire             want     = started & ~done & ~phase;
  wire             zc_on    = ZC_CAPABLE & zc_mode;
  wire             crossing = smp_valid & (smp_sign ^ prev_sign);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      done      <= 1'b0;
      phase     <= 1'b0;
      prev_sign <= 1'b0;
      cnt       <= ZERO;
      tone_on   <= 1'b0;
      act_irq   <= 1'b0;
      inact_irq <= 1'b0;
    end else begin
      act_irq   <= 1'b0;
      inact_irq <= 1'b0;
      if (smp_valid) prev_sign <= smp_sign;
      if (!zc_on || crossing) tone_on <= want;

      if (!osc_en) begin
        started <= 1'b0;
        done    <= 1'b0;
        phase   <= 1'b0;
        cnt     <= ZERO;
      end else if (!started) begin
        started <= 1'b1;
        cnt     <= ZERO;
        phase   <= act_en & inact_en & (act_len == ZERO);
        done    <= act_en & ~inact_en & (act_len == ZERO);
      end else if (expire) begin
        cnt <= ZERO;
        if (!phase) begin
          act_irq <= 1'b1;
          if (!inact_en)              done  <= 1'b1;
          else if (inact_len != ZERO) phase <= 1'b1;
        end else begin
          inact_irq <= 1'b1;
          if (act_len != ZERO) phase <= 1'b0;
        end
      end else if (step) begin
        cnt <= cnt + ONE;
      end
    end
  end

endmodule

// File: rtl/tone_cadence_chk.sv
module tone_cadence_chk #(
  parameter bit ZC_CAPABLE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic osc_en,
  input logic zc_mode,
  input logic tone_on,
  input logic act_irq,
  input logic inact_irq
);

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_irq && inact_irq)); // R4

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_irq || inact_irq) |-> ($past(smp_valid) && $past(osc_en))); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!act_irq && !inact_irq)); // R7

  AST_STOP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !zc_mode) ##1 !zc_mode |=> !tone_on); // R7

  AST_ZC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ZC_CAPABLE != 1'b0) && zc_mode && !smp_valid) |=> $stable(tone_on)); // R8

endmodule

bind tone_cadence_timer tone_cadence_chk #(.ZC_CAPABLE(ZC_CAPABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .osc_en(osc_en),
  .zc_mode(zc_mode), .tone_on(tone_on), .act_irq(act_irq), .inact_irq(inact_irq)
);

// File: tb/tb_tone_cadence_timer.sv
module tb_tone_cadence_timer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_sign = 1'b0, osc_en = 1'b0;
  logic act_en = 1'b0, inact_en = 1'b0, zc_mode = 1'b0;
  logic [W-1:0] act_len = '0, inact_len = '0;
  logic tone_on, act_irq, inact_irq;
  logic tone_nz, act_nz, inact_nz;
  int compared = 0, mismatched = 0;
  bit last_sign = 1'b0;

  always #2 clk = ~clk;

  tone_cadence_timer #(.CNT_W(W), .ZC_CAPABLE(1'b1)) dut (
    .clk, .rst_n, .smp_valid, .smp_sign, .osc_en, .act_en, .inact_en, .zc_mode,
    .act_len, .inact_len, .tone_on, .act_irq, .inact_irq);

  tone_cadence_timer #(.CNT_W(W), .ZC_CAPABLE(1'b0)) dut_nozc (
    .clk, .rst_n, .smp_valid, .smp_sign, .osc_en, .act_en, .inact_en, .zc_mode,
    .act_len, .inact_len, .tone_on(tone_nz), .act_irq(act_nz), .inact_irq(inact_nz));

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit on_at(int mode, int a, int i, int k);
    int p = a + i;
    if (mode == 0) return 1'b1;
    if (mode == 1) return k < a;
    if (p == 0) return 1'b0;
    return (k % p) < a;
  endfunction

  function automatic bit act_exp(int mode, int a, int i, int n);
    int p = a + i;
    if (mode == 1) return (a > 0) && (n == a);
    if (mode == 2) return (a > 0) && (n >= a) && (((n - a) % p) == 0);
    return 1'b0;
  endfunction

  function automatic bit inact_exp(int mode, int a, int i, int n);
    int p = a + i;
    return (mode == 2) && (i > 0) && (n > 0) && ((n % p) == 0);
  endfunction

  task automatic run_cfg(int mode, int a, int i, int nt, bit zc, int sp, string tag);
    bit lat = 1'b0;
    @(negedge clk) osc_en = 1'b0; zc_mode = 1'b0;
    repeat (3) @(negedge clk);
    act_en = (mode != 0); inact_en = (mode == 2);
    act_len = W'(a); inact_len = W'(i); zc_mode = zc;
    @(negedge clk) osc_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 1; n <= nt; n++) begin
      bit s;
      s = bit'((n / sp) % 2);
      if (s != last_sign) lat = on_at(mode, a, i, n - 1);
      last_sign = s;
      smp_valid = 1'b1; smp_sign = s;
      @(negedge clk) smp_valid = 1'b0;
      chk($sformatf("%s act_irq mode=%0d A=%0d I=%0d n=%0d", tag, mode, a, i, n),
          act_irq, act_exp(mode, a, i, n));
      chk($sformatf("%s inact_irq mode=%0d A=%0d I=%0d n=%0d", tag, mode, a, i, n),
          inact_irq, inact_exp(mode, a, i, n));
      @(negedge clk);
      chk($sformatf("R4 irq width n=%0d", n), act_irq | inact_irq, 1'b0);
      if (zc) begin
        chk($sformatf("R8 tone A=%0d I=%0d sp=%0d n=%0d", a, i, sp, n), tone_on, lat);
        chk($sformatf("R9 tone A=%0d I=%0d n=%0d", a, i, n), tone_nz, on_at(mode, a, i, n));
      end else begin
        chk($sformatf("%s tone mode=%0d A=%0d I=%0d n=%0d", tag, mode, a, i, n),
            tone_on, on_at(mode, a, i, n));
      end
      @(negedge clk);
    end
  endtask

  task automatic bare_tick(bit s);
    smp_valid = 1'b1; smp_sign = s; last_sign = s;
    @(negedge clk) smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tone_on", tone_on, 1'b0);
    chk("R1 act_irq", act_irq, 1'b0);
    chk("R1 inact_irq", inact_irq, 1'b0);

    run_cfg(0, 0, 0, 5, 1'b0, 1, "R2");
    run_cfg(0, 2, 3, 8, 1'b0, 1, "R2");

    for (int a = 0; a <= 3; a++)
      for (int i = 0; i <= 3; i++)
        run_cfg(2, a, i, 2 * (a + i) + 4, 1'b0, 1, (a == 0 || i == 0) ? "R6" : "R3");
    run_cfg(2, 700, 5, 710, 1'b0, 1, "R3");

    for (int a = 0; a <= 4; a++)
      run_cfg(1, a, 0, a + 3, 1'b0, 1, (a == 0) ? "R6" : "R5");

    // R7: stop mid-burst, stay quiet, restart fresh
    run_cfg(2, 3, 2, 2, 1'b0, 1, "R7");
    @(negedge clk) osc_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 tone off after clear", tone_on, 1'b0);
    for (int k = 0; k < 4; k++) begin
      smp_valid = 1'b1; smp_sign = ~last_sign; last_sign = ~last_sign;
      @(negedge clk) smp_valid = 1'b0;
      chk("R7 no act_irq while off", act_irq, 1'b0);
      chk("R7 no inact_irq while off", inact_irq, 1'b0);
      @(negedge clk);
      chk("R7 tone stays off", tone_on, 1'b0);
    end
    run_cfg(2, 3, 2, 10, 1'b0, 1, "R7");

    // R8: zero-cross gating, including crossings that land on expiries
    for (int sp = 1; sp <= 3; sp++) begin
      run_cfg(2, 2, 3, 15, 1'b1, sp, "R8");
      run_cfg(2, 3, 1, 15, 1'b1, sp, "R8");
      run_cfg(2, 1, 2, 15, 1'b1, sp, "R8");
    end

    // R8: switched off tone keeps sounding until a sign change
    run_cfg(2, 5, 0, 3, 1'b1, 1, "R8");
    @(negedge clk) osc_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      bare_tick(last_sign);
      chk("R8 hold until crossing", tone_on, 1'b1);
    end
    bare_tick(~last_sign);
    chk("R8 off at crossing", tone_on, 1'b0);
    chk("R9 no-zc instance off", tone_nz, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule